// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host port and an external asynchronous static RAM of 64K words by 16 bits. The RAM has one active-high select and one active-low enable per byte. The host offers one request at a time through a valid/ready handshake. Each request carries an address, a direction flag, write data and a per-byte mask. The controller then plays out the pin sequence the RAM needs. Read data comes back with a single-cycle valid pulse.

The length of every phase is derived from nanosecond minimums and the clock period parameter `CLK_NS`. The derivation is a ceiling division with a floor of one cycle. At the default 20 ns clock this gives the following counts:

- The write-strobe low window lasts 5 cycles.
- A read access window lasts 6 cycles.
- After a read, 2 cycles must pass before the controller drives the bus again.

All memory-side pins come straight from registers. When no request is in flight, the pins rest in a deselected, quiet state.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and in every cycle where `req_ready` is high, the pins are parked: `mem_cs`=0, `mem_bc_n` all ones, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access has finished.
- R3: While `mem_cs` is high, `mem_bc_n[i]` is low exactly when `req_mask[i]` of the current request was 1. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. While `mem_cs` is low, every byte enable is high.
- R4: A write proceeds in three stages:
  - One setup cycle: `mem_cs` high, the byte enables set, `mem_dq_oe` high and `mem_we_n` high.
  - `mem_we_n` low for 5 cycles at the default timing.
  - `mem_we_n` rises while `mem_cs`, the byte enables and `mem_dq_oe` are still asserted.
  `mem_cs` stays high for at least 120 ns per access.
- R5: `mem_oe_n` is high in every cycle where `mem_we_n` is low or `mem_dq_oe` is high.
- R6: A read holds `mem_cs` high, `mem_oe_n` low and `mem_we_n` high for 6 cycles at the default timing. The bus is sampled on the clock edge that ends the last of these cycles. `rsp_valid` is high for exactly one cycle, 7 cycles after the accepting edge.
- R7: In `rsp_rdata`, the bytes whose mask bit was 0 read as zero. A request with mask 0 asserts no byte enable: a write changes nothing, and a read returns 0.
- R8: `mem_dq_oe` rises only after `mem_oe_n` has been high for at least 2 full cycles (40 ns) since the last cycle it was low.
- R9: `mem_addr` does not change while `mem_cs` stays high.
- R10: A read returns the latest data written to that address, merged byte by byte across partial writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit i enables byte i |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 16 | RAM address |
| mem_cs | output | 1 | RAM select, active high |
| mem_bc_n | output | 2 | Per-byte enables, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_i | input | 16 | Data bus from the pad |
| mem_dq_o | output | 16 | Data bus to the pad |
| mem_dq_oe | output | 1 | Pad driver enable |

## Verification
The bench contains a RAM model that takes pin activity over time into account. On a read, it drives junk until 120 ns have passed since the address and enables settled. It also drives junk on byte lanes that are not enabled. As a result, two kinds of faulty design return wrong data: one whose read window is too short, and one that fails to zero unselected bytes.

A write is committed only at the rising edge of the write strobe, and only if the pulse was long enough. A design that drops the select or the data first therefore loses data and is reported.

The bench also issues a write immediately after a read, to test bus turnaround. A missing turnaround gap shows up as the controller driving within 40 ns of the RAM releasing the bus.

Mask-zero requests and merges of partial writes cover the byte-lane corners.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_TURN = 3'd1,
        PH_WSET = 3'd2,
        PH_WPUL = 3'd3,
        PH_WEND = 3'd4,
        PH_RACC = 3'd5
    } phase_e;

    // Cycles covering a nanosecond minimum, never fewer than one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_gate.sv
`timescale 1ns/1ps
module sram_lane_gate #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_i,
    output logic [LANES-1:0]  bc_n,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bc_n[g]          = ~mask[g];
        assign rd_data[g*8 +: 8] = mask[g] ? dq_i[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_gap_track.sv
`timescale 1ns/1ps
module sram_gap_track #(
    parameter int unsigned TA_CYC = 2,
    localparam int unsigned GW = $clog2(TA_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n_q,
    output logic gap_ok
);

    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        if (!oe_n_q) begin
            gap_d = '0;
        end else if (gap_q == GW'(TA_CYC)) begin
            gap_d = gap_q;
        end else begin
            gap_d = gap_q + GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GW'(TA_CYC);
        end else begin
            gap_q <= gap_d;
        end
    end

    // Driving may start next cycle once the quiet cycles so far plus this one suffice.
    assign gap_ok = ({1'b0, gap_q} + (GW+1)'(1)) >= (GW+1)'(TA_CYC);

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CLK_NS   = 20,
    parameter int unsigned T_WP_NS  = 85,
    parameter int unsigned T_AW_NS  = 100,
    parameter int unsigned T_CW_NS  = 100,
    parameter int unsigned T_DS_NS  = 45,
    parameter int unsigned T_WC_NS  = 120,
    parameter int unsigned T_AA_NS  = 120,
    parameter int unsigned T_OA_NS  = 60,
    parameter int unsigned T_DIS_NS = 40,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs,
    output logic [LANES-1:0]  mem_bc_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    localparam int unsigned WP_CYC = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                          umax(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)));
    localparam int unsigned WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned TAIL_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 1;
    localparam int unsigned RD_CYC = umax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OA_NS, CLK_NS));
    localparam int unsigned TA_CYC = ns_to_cyc(T_DIS_NS, CLK_NS);
    localparam int unsigned MAX_CYC = umax(umax(WP_CYC, RD_CYC), TAIL_CYC);
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
        logic              cs;
        logic [LANES-1:0]  bc_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [LANES-1:0]  mask_sel;
    logic [LANES-1:0]  bc_n_sel;
    logic [DATA_W-1:0] rd_masked;
    logic              gap_ok;

    assign mask_sel = (r_q.st == PH_IDLE) ? req_mask : r_q.mask;

    sram_lane_gate #(.DATA_W(DATA_W)) u_gate (
        .mask    (mask_sel),
        .dq_i    (mem_dq_i),
        .bc_n    (bc_n_sel),
        .rd_data (rd_masked)
    );

    sram_gap_track #(.TA_CYC(TA_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n_q (r_q.oe_n),
        .gap_ok (gap_ok)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        case (r_q.st)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mask  = req_mask;
                    if (req_write) begin
                        if (gap_ok) begin
                            r_d.st    = PH_WSET;
                            r_d.cs    = 1'b1;
                            r_d.bc_n  = bc_n_sel;
                            r_d.dq_oe = 1'b1;
                        end else begin
                            r_d.st = PH_TURN;
                        end
                    end else begin
                        r_d.st   = PH_RACC;
                        r_d.cs   = 1'b1;
                        r_d.bc_n = bc_n_sel;
                        r_d.oe_n = 1'b0;
                        r_d.cnt  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_TURN: begin
                if (gap_ok) begin
                    r_d.st    = PH_WSET;
                    r_d.cs    = 1'b1;
                    r_d.bc_n  = bc_n_sel;
                    r_d.dq_oe = 1'b1;
                end
            end
            PH_WSET: begin
                r_d.st   = PH_WPUL;
                r_d.we_n = 1'b0;
                r_d.cnt  = CNT_W'(WP_CYC - 1);
            end
            PH_WPUL: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = PH_WEND;
                    r_d.we_n = 1'b1;
                    r_d.cnt  = CNT_W'(TAIL_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            PH_WEND: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = PH_IDLE;
                    r_d.cs    = 1'b0;
                    r_d.bc_n  = '1;
                    r_d.dq_oe = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            PH_RACC: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = PH_IDLE;
                    r_d.rdata  = rd_masked;
                    r_d.rvalid = 1'b1;
                    r_d.cs     = 1'b0;
                    r_d.bc_n   = '1;
                    r_d.oe_n   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                r_d.st    = PH_IDLE;
                r_d.cs    = 1'b0;
                r_d.bc_n  = '1;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= PH_IDLE;
            r_q.bc_n <= '1;
            r_q.we_n <= 1'b1;
            r_q.oe_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == PH_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_rdata = r_q.rdata;
    assign mem_addr  = r_q.addr;
    assign mem_cs    = r_q.cs;
    assign mem_bc_n  = r_q.bc_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_o  = r_q.wdata;
    assign mem_dq_oe = r_q.dq_oe;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CLK_NS   = 20,
    parameter int unsigned T_DIS_NS = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs,
    input logic [DATA_W/8-1:0] mem_bc_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    localparam int unsigned TA = ns_to_cyc(T_DIS_NS, CLK_NS);
    localparam int unsigned QW = $clog2(TA + 1);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= QW'(TA);
        end else if (!mem_oe_n) begin
            quiet_q <= '0;
        end else if (quiet_q != QW'(TA)) begin
            quiet_q <= quiet_q + QW'(1);
        end
    end

    // R1
    parked_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_cs && (&mem_bc_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3
    lanes_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs |-> (&mem_bc_n));

    // R4
    we_fall_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_cs) && $past(mem_dq_oe)));

    // R4
    we_rise_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_cs && mem_dq_oe));

    // R5
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R5
    oe_off_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    bus_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (quiet_q >= QW'(TA)));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs && $past(mem_cs)) |-> $stable(mem_addr));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLK_NS   (CLK_NS),
    .T_DIS_NS (T_DIS_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs    (mem_cs),
    .mem_bc_n  (mem_bc_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

    localparam int CLK  = 20;
    localparam int RD_N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs;
    logic [1:0]  mem_bc_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [15:0] mem_dq_i = 16'hBEEF;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;

    always #(CLK/2) clk = ~clk;

    sram_lane_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_bc_n(mem_bc_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    int cyc = 0;

    logic [15:0] golden [256];
    logic [15:0] pin_mem [256];
    logic [15:0] exp_d [$];
    int          exp_due [$];
    logic [1:0]  cur_mask = 2'b00;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Pin-level RAM model and per-clock comparison
    logic        prev_cs = 1'b0;
    logic        prev_we_n = 1'b1;
    logic        prev_rd = 1'b0;
    logic [15:0] prev_addr = '0;
    int          cs_cnt = 0;
    int          we_lo = 0;
    int          rd_cnt = 0;
    longint      last_dev = 0;
    bit          dev_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic rd_act;
            if (rsp_valid) begin
                if (exp_d.size() == 0) begin
                    chk(0, "R6 response without read", rsp_rdata, 0);
                end else begin
                    logic [15:0] d;
                    int due;
                    d = exp_d.pop_front();
                    due = exp_due.pop_front();
                    chk(rsp_rdata == d, "R10 R7 read data", rsp_rdata, d);
                    chk(cyc == due, "R6 response cycle", cyc, due);
                end
            end else if (exp_due.size() > 0 && exp_due[0] < cyc) begin
                chk(0, "R6 response missing", cyc, exp_due[0]);
                void'(exp_d.pop_front());
                void'(exp_due.pop_front());
            end
            if (req_ready)
                chk(!mem_cs && mem_bc_n == 2'b11 && mem_we_n && mem_oe_n && !mem_dq_oe,
                    "R1 parked pins", {mem_cs, mem_bc_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b011110);
            if (mem_cs)
                chk(mem_bc_n == ~cur_mask, "R3 lane enables", mem_bc_n, ~cur_mask);
            else
                chk(mem_bc_n == 2'b11, "R3 lanes off", mem_bc_n, 2'b11);
            if (mem_cs && prev_cs)
                chk(mem_addr == prev_addr, "R9 address hold", mem_addr, prev_addr);
            if (!mem_we_n) begin
                chk(mem_oe_n && mem_dq_oe && mem_cs, "R5 write pin state",
                    {mem_oe_n, mem_dq_oe, mem_cs}, 3'b111);
                we_lo++;
            end
            if (mem_we_n && !prev_we_n) begin
                chk(mem_cs && mem_dq_oe, "R4 strobe rises first", {mem_cs, mem_dq_oe}, 2'b11);
                chk(we_lo * CLK >= 85, "R4 pulse width ns", we_lo * CLK, 85);
                chk(cs_cnt * CLK >= 100, "R4 select before end ns", cs_cnt * CLK, 100);
                if (mem_cs) begin
                    if (!mem_bc_n[0]) pin_mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
                    if (!mem_bc_n[1]) pin_mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
                end
                we_lo = 0;
            end
            if (!mem_cs && prev_cs) begin
                chk(cs_cnt * CLK >= 120, "R4 R6 access length ns", cs_cnt * CLK, 120);
                cs_cnt = 0;
            end
            if (mem_cs) cs_cnt++;
            if (mem_cs && !mem_oe_n && mem_we_n && mem_bc_n != 2'b11) begin
                last_dev = longint'($time);
                dev_seen = 1;
            end
            if (mem_dq_oe && dev_seen)
                chk((longint'($time) - 10) - (last_dev + 10) >= 40, "R8 turnaround ns",
                    (longint'($time) - 10) - (last_dev + 10), 40);
            rd_act = mem_cs && !mem_oe_n && mem_we_n;
            if (rd_act && prev_rd && mem_addr == prev_addr) rd_cnt++;
            else if (rd_act) rd_cnt = 1;
            else rd_cnt = 0;
            for (int l = 0; l < 2; l++) begin
                if (rd_act && !mem_bc_n[l] && rd_cnt * CLK >= 120)
                    mem_dq_i[l*8 +: 8] = pin_mem[mem_addr[7:0]][l*8 +: 8];
                else
                    mem_dq_i[l*8 +: 8] = 8'hA5;
            end
            prev_rd   = rd_act;
            prev_cs   = mem_cs;
            prev_we_n = mem_we_n;
            prev_addr = mem_addr;
        end
    end

    task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        cur_mask  = m;
        if (wr) begin
            if (m[0]) golden[a[7:0]][7:0]  = d[7:0];
            if (m[1]) golden[a[7:0]][15:8] = d[15:8];
        end else begin
            exp_d.push_back(golden[a[7:0]] & {{8{m[1]}}, {8{m[0]}}});
            exp_due.push_back(cyc + RD_N + 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 taken when valid and ready", req_ready, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            golden[i]  = '0;
            pin_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk(!mem_cs && mem_bc_n == 2'b11 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 reset pins", {mem_cs, mem_bc_n, mem_we_n, mem_oe_n, mem_dq_oe}, 6'b011110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        do_req(1, 16'h0010, 16'h1234, 2'b11);
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        do_req(1, 16'h0010, 16'hABCD, 2'b01);
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        do_req(1, 16'h0010, 16'h5566, 2'b10);
        do_req(0, 16'h0010, 16'h0000, 2'b01);
        do_req(0, 16'h0010, 16'h0000, 2'b10);
        // R8: write right behind a read
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        do_req(1, 16'h0020, 16'h7788, 2'b11);
        do_req(0, 16'h0020, 16'h0000, 2'b11);
        // R7: empty mask
        do_req(1, 16'h0010, 16'hFFFF, 2'b00);
        do_req(0, 16'h0010, 16'h0000, 2'b00);
        do_req(0, 16'h0010, 16'h0000, 2'b11);
        begin
            logic [31:0] s;
            s = 32'h1357_9BDF;
            for (int i = 0; i < 40; i++) begin
                s = s * 32'd1103515245 + 32'd12345;
                do_req(s[13], {12'h000, s[7:4]}, s[31:16], s[9:8]);
            end
        end
        repeat (12) @(negedge clk);
        chk(exp_d.size() == 0, "R6 all reads answered", exp_d.size(), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule